// File: doc/BRIEF.md
# Accumulator ALU with Shift Variants

This block is the arithmetic and logic unit of a 32-bit accumulator machine, together with the accumulator register and its two status flags. Each cycle it takes a 4-bit operation code, the current accumulator and one 32-bit operand. The operand is either a data word or an instruction immediate. From these it forms a new accumulator value.

The operations fall into four groups:
- plain load
- add or subtract, wrapping modulo 2^32
- bitwise AND, OR and XOR
- single-bit moves: left or right shifts with a selectable fill bit (zero, one, or the old end bit kept in place), and rotates

When the write strobe is high, the result and its zero and negative flags are captured together on the rising clock edge. The result path is purely combinational, so the registered outputs show the new value one edge after the stimulus.

Top module: `acc_alu_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the accumulator is 0, the zero flag is 1 and the negative flag is 0.
- R2: Code 0 (load) writes the operand unchanged, all 32 bits, to the accumulator. This holds even when `imm_i` is 1.
- R3: Code 1 (add) writes accumulator plus operand modulo 2^32. No carry is kept.
- R4: Code 2 (subtract) writes accumulator minus operand modulo 2^32.
- R5: When `imm_i` is 1, add and subtract use only operand bits 27:0, zero-extended. Operand bits 31:28 have no effect on the result.
- R6: Codes 3, 4 and 5 write the bitwise AND, OR and XOR of the accumulator and the operand.
- R7: Codes 6, 7 and 8 shift the accumulator left by one bit. The new bit 0 is 0 for code 6, 1 for code 7, and the old bit 0 for code 8.
- R8: Codes 10, 11 and 12 shift the accumulator right by one bit. The new bit 31 is 0 for code 10, 1 for code 11, and the old bit 31 for code 12.
- R9: Code 9 rotates left, moving old bit 31 into bit 0. Code 13 rotates right, moving old bit 0 into bit 31.
- R10: After every write, the zero flag is 1 exactly when the new accumulator is all zeros.
- R11: After every write, the negative flag equals bit 31 of the new accumulator.
- R12: On an edge where `wr_en_i` is 0, the accumulator and both flags keep their values, whatever the code and operand.
- R13: Codes 14 and 15 write the current accumulator back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Capture result and flags on this edge |
| op_i | input | 4 | Operation code |
| imm_i | input | 1 | Operand is an instruction immediate |
| operand_i | input | 32 | Data word or immediate operand |
| acc_o | output | 32 | Accumulator |
| zero_o | output | 1 | Accumulator is zero |
| neg_o | output | 1 | Accumulator bit 31 |

## Verification
Every result is due one rising edge after the bench presents the code, operand and write strobe. No other register lies between the inputs and `acc_o`, `zero_o` and `neg_o`. The bench changes inputs on the falling edge and reads the outputs on the following falling edge, half a period after the capturing edge. To set a start value, it first loads the accumulator in its own cycle and then issues the operation under test. Each result is therefore read exactly one edge after its own stimulus.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_LOAD = 4'd0,
      OP_ADD  = 4'd1,
      OP_SUB  = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_SHL0 = 4'd6,
      OP_SHL1 = 4'd7,
      OP_SHLK = 4'd8,
      OP_ROL  = 4'd9,
      OP_SHR0 = 4'd10,
      OP_SHR1 = 4'd11,
      OP_SHRK = 4'd12,
      OP_ROR  = 4'd13
   } alu_op_e;

   typedef enum logic [1:0] {
      GRP_PASS,
      GRP_ARITH,
      GRP_MOVE,
      GRP_BITS
   } alu_grp_e;

   typedef enum logic [1:0] {
      FILL_ZERO,
      FILL_ONE,
      FILL_KEEP,
      FILL_WRAP
   } fill_e;

   typedef enum logic [1:0] {
      BW_AND,
      BW_OR,
      BW_XOR,
      BW_NONE
   } bw_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 28
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              imm_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] res_o
);
   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] b_eff;

   generate
      if (PAD_W > 0) begin : g_pad
         assign b_eff = imm_i ? {{PAD_W{1'b0}}, b_i[IMM_W-1:0]} : b_i;
      end else begin : g_nopad
         assign b_eff = b_i;
      end
   endgenerate

   assign res_o = sub_i ? (a_i - b_eff) : (a_i + b_eff);

   always_comb begin
      if (sub_i) begin
         AST_SUB_UNDOES: assert ((res_o + b_eff) == a_i); // R4
      end
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              left_i,
   input  fill_e             fill_i,
   output logic [DATA_W-1:0] res_o
);
   localparam int MSB = DATA_W - 1;

   logic fill_bit;

   always_comb begin
      unique case (fill_i)
         FILL_ZERO: fill_bit = 1'b0;
         FILL_ONE:  fill_bit = 1'b1;
         FILL_KEEP: fill_bit = left_i ? a_i[0]   : a_i[MSB];
         default:   fill_bit = left_i ? a_i[MSB] : a_i[0];
      endcase
   end

   assign res_o = left_i ? {a_i[MSB-1:0], fill_bit} : {fill_bit, a_i[MSB:1]};

   always_comb begin
      if (fill_i == FILL_WRAP) begin
         AST_ROTATE_KEEPS_ONES: assert ($countones(res_o) == $countones(a_i)); // R9
      end
   end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  bw_e               sel_i,
   output logic [DATA_W-1:0] res_o
);
   for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      always_comb begin
         unique case (sel_i)
            BW_AND:  res_o[k] = a_i[k] & b_i[k];
            BW_OR:   res_o[k] = a_i[k] | b_i[k];
            BW_XOR:  res_o[k] = a_i[k] ^ b_i[k];
            default: res_o[k] = a_i[k];
         endcase
      end
   end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 28,
   parameter int OP_W   = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic              imm_i,
   input  logic [DATA_W-1:0] operand_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              zero_o,
   output logic              neg_o
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("acc_alu_unit: DATA_W must be at least 2");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("acc_alu_unit: IMM_W must lie in 1..DATA_W");
      end
      if (OP_W != 4) begin : g_bad_op
         $error("acc_alu_unit: OP_W must be 4");
      end
   endgenerate

   logic [DATA_W-1:0] acc_q;
   logic              zero_q, neg_q;

   alu_grp_e          grp;
   logic              sub, left;
   fill_e             fill;
   bw_e               bw_sel;
   logic [DATA_W-1:0] arith_res, move_res, bits_res, result;

   always_comb begin
      grp    = GRP_PASS;
      sub    = 1'b0;
      left   = 1'b0;
      fill   = FILL_ZERO;
      bw_sel = BW_NONE;
      unique case (op_i)
         OP_LOAD: grp = GRP_PASS;
         OP_ADD:  grp = GRP_ARITH;
         OP_SUB:  begin grp = GRP_ARITH; sub = 1'b1; end
         OP_AND:  begin grp = GRP_BITS; bw_sel = BW_AND; end
         OP_OR:   begin grp = GRP_BITS; bw_sel = BW_OR;  end
         OP_XOR:  begin grp = GRP_BITS; bw_sel = BW_XOR; end
         OP_SHL0: begin grp = GRP_MOVE; left = 1'b1; fill = FILL_ZERO; end
         OP_SHL1: begin grp = GRP_MOVE; left = 1'b1; fill = FILL_ONE;  end
         OP_SHLK: begin grp = GRP_MOVE; left = 1'b1; fill = FILL_KEEP; end
         OP_ROL:  begin grp = GRP_MOVE; left = 1'b1; fill = FILL_WRAP; end
         OP_SHR0: begin grp = GRP_MOVE; fill = FILL_ZERO; end
         OP_SHR1: begin grp = GRP_MOVE; fill = FILL_ONE;  end
         OP_SHRK: begin grp = GRP_MOVE; fill = FILL_KEEP; end
         OP_ROR:  begin grp = GRP_MOVE; fill = FILL_WRAP; end
         default: grp = GRP_BITS;
      endcase
   end

   alu_addsub #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_addsub (
      .a_i   (acc_q),
      .b_i   (operand_i),
      .imm_i (imm_i),
      .sub_i (sub),
      .res_o (arith_res)
   );

   alu_shifter #(.DATA_W(DATA_W)) i_shifter (
      .a_i    (acc_q),
      .left_i (left),
      .fill_i (fill),
      .res_o  (move_res)
   );

   alu_bitwise #(.DATA_W(DATA_W)) i_bitwise (
      .a_i   (acc_q),
      .b_i   (operand_i),
      .sel_i (bw_sel),
      .res_o (bits_res)
   );

   always_comb begin
      unique case (grp)
         GRP_ARITH: result = arith_res;
         GRP_MOVE:  result = move_res;
         GRP_BITS:  result = bits_res;
         default:   result = operand_i;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         zero_q <= 1'b1;
         neg_q  <= 1'b0;
      end else if (wr_en_i) begin
         acc_q  <= result;
         zero_q <= (result == '0);
         neg_q  <= result[MSB];
      end
   end

   assign acc_o  = acc_q;
   assign zero_o = zero_q;
   assign neg_o  = neg_q;

   AST_HOLD_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(acc_q)); // R12
   AST_HOLD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable({zero_q, neg_q})); // R12
   AST_ZERO_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_q == (acc_q == '0)); // R10
   AST_NEG_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      neg_q == acc_q[MSB]); // R11
endmodule

// File: tb/test_acc_alu_unit.sv
`timescale 1ns/100ps
module test_acc_alu_unit;

   typedef struct packed {
      logic [3:0]  op;
      logic        imm;
      logic [31:0] start;
      logic [31:0] opnd;
      logic [31:0] expect_v;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{4'd1,  1'b0, 32'h0000_0005, 32'h0000_0003, 32'h0000_0008},
      '{4'd1,  1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
      '{4'd2,  1'b0, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
      '{4'd2,  1'b0, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000},
      '{4'd1,  1'b1, 32'h0000_0010, 32'hF000_0001, 32'h0000_0011},
      '{4'd2,  1'b1, 32'h0000_0000, 32'hA000_0001, 32'hFFFF_FFFF},
      '{4'd0,  1'b1, 32'h0000_0000, 32'hF000_0000, 32'hF000_0000},
      '{4'd0,  1'b0, 32'h7777_7777, 32'h0000_0000, 32'h0000_0000},
      '{4'd3,  1'b0, 32'hFF00_FF00, 32'h0F0F_0F0F, 32'h0F00_0F00},
      '{4'd4,  1'b0, 32'hF000_0000, 32'h0000_000F, 32'hF000_000F},
      '{4'd5,  1'b0, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h0000_0000},
      '{4'd6,  1'b0, 32'h8000_0001, 32'h0000_0000, 32'h0000_0002},
      '{4'd7,  1'b0, 32'h8000_0000, 32'h0000_0000, 32'h0000_0001},
      '{4'd8,  1'b0, 32'h0000_0003, 32'h0000_0000, 32'h0000_0007},
      '{4'd8,  1'b0, 32'h0000_0002, 32'h0000_0000, 32'h0000_0004},
      '{4'd9,  1'b0, 32'h8000_0001, 32'h0000_0000, 32'h0000_0003},
      '{4'd10, 1'b0, 32'h8000_0001, 32'h0000_0000, 32'h4000_0000},
      '{4'd11, 1'b0, 32'h0000_0002, 32'h0000_0000, 32'h8000_0001},
      '{4'd12, 1'b0, 32'h8000_0000, 32'h0000_0000, 32'hC000_0000},
      '{4'd12, 1'b0, 32'h4000_0000, 32'h0000_0000, 32'h2000_0000},
      '{4'd13, 1'b0, 32'h0000_0001, 32'h0000_0000, 32'h8000_0000},
      '{4'd14, 1'b0, 32'h0000_0055, 32'hFFFF_FFFF, 32'h0000_0055}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  op = 4'd0;
   logic        imm = 1'b0;
   logic [31:0] operand = '0;
   logic [31:0] acc;
   logic        zero, neg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   acc_alu_unit i_acc_alu_unit (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .op_i      (op),
      .imm_i     (imm),
      .operand_i (operand),
      .acc_o     (acc),
      .zero_o    (zero),
      .neg_o     (neg)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [3:0] o, logic im, logic [31:0] d, logic we);
      @(negedge clk);
      op = o; imm = im; operand = d; wr_en = we;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic string tag_of(logic [3:0] o, logic im);
      if (im && (o == 4'd1 || o == 4'd2)) return "R5";
      case (o)
         4'd0: return "R2";
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3, 4'd4, 4'd5: return "R6";
         4'd6, 4'd7, 4'd8: return "R7";
         4'd10, 4'd11, 4'd12: return "R8";
         4'd9, 4'd13: return "R9";
         default: return "R13";
      endcase
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state, during reset and right after release
      repeat (2) @(negedge clk);
      check("R1", acc, 32'h0);
      check("R1", {31'd0, zero}, 32'd1);
      check("R1", {31'd0, neg}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", acc, 32'h0);
      check("R1", {31'd0, zero}, 32'd1);

      // vector table: load start value, then apply the operation
      for (int i = 0; i < NV; i++) begin
         apply(4'd0, 1'b0, VECS[i].start, 1'b1);
         apply(VECS[i].op, VECS[i].imm, VECS[i].opnd, 1'b1);
         check(tag_of(VECS[i].op, VECS[i].imm), acc, VECS[i].expect_v);
         check("R10", {31'd0, zero}, {31'd0, (VECS[i].expect_v == 32'h0)});
         check("R11", {31'd0, neg}, {31'd0, VECS[i].expect_v[31]});
      end

      // R13: code 15 holds the value too
      apply(4'd0, 1'b0, 32'h8000_00AA, 1'b1);
      apply(4'd15, 1'b1, 32'h0000_0000, 1'b1);
      check("R13", acc, 32'h8000_00AA);

      // R12: no write strobe means nothing changes
      apply(4'd0, 1'b0, 32'h8000_0000, 1'b1);
      apply(4'd0, 1'b0, 32'h0000_0000, 1'b0);
      check("R12", acc, 32'h8000_0000);
      check("R12", {30'd0, zero, neg}, {30'd0, 1'b0, 1'b1});
      apply(4'd7, 1'b0, 32'h0000_0000, 1'b0);
      check("R12", acc, 32'h8000_0000);

      // R5: high immediate bits ignored, same low bits give same result
      apply(4'd0, 1'b0, 32'h0000_0100, 1'b1);
      apply(4'd1, 1'b1, 32'h5000_0010, 1'b1);
      check("R5", acc, 32'h0000_0110);
      apply(4'd2, 1'b1, 32'hF000_0110, 1'b1);
      check("R5", acc, 32'h0000_0000);
      check("R10", {31'd0, zero}, 32'd1);

      // R1: reset in mid-run clears state
      apply(4'd0, 1'b0, 32'hDEAD_BEEF, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", acc, 32'h0);
      check("R1", {30'd0, zero, neg}, {30'd0, 1'b1, 1'b0});
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule